// File: doc/BRIEF.md
# Low-Side Bus Current Trip Controller

This block protects a three-phase bridge against excessive current in the low-side DC-bus return. Two digital flags arrive from external comparators. One flag marks a moderate over-current level. The other marks a much higher short-circuit level. Each flag must stay high for its own number of consecutive clock cycles before it counts as a trip. A short flag therefore trips quickly. A long but moderate excess needs a longer qualification time.

On a trip, every low-side gate drive is forced off in the same cycle. An active-low fault pin is pulled low for a fixed number of cycles. After the fault pulse ends, each low-side channel stays blocked until its own command input is sampled in the OFF state. Only then does that channel follow its command again. A command held ON through the end of the pulse cannot switch its switch back on.

Top module: `lsTripGuard`

## Requirements
- R1: After reset, `faultN` is 1 and each `gateLo[i]` equals `cmdLo[i]` in the same cycle. Bit i is channel i, and 1 means switch ON. This also holds while `rstN` is low.
- R2: A trip occurs at the clock edge that samples `scFlag` high for the `SC_QUAL_CYC`-th consecutive time. `SC_QUAL_CYC`-1 consecutive high samples cause no trip.
- R3: A trip occurs at the clock edge that samples `ocFlag` high for the `OC_QUAL_CYC`-th consecutive time. `OC_QUAL_CYC`-1 consecutive high samples cause no trip.
- R4: A single low sample of a flag restarts its qualification count from zero.
- R5: From the edge of a trip onward, all `gateLo` bits are 0 whatever the commands are, for as long as `faultN` is 0.
- R6: `faultN` goes low at the trip edge. It stays low for exactly `FAULT_CYC` clock cycles, then returns high.
- R7: A flag that qualifies while `faultN` is low neither restarts nor lengthens the fault pulse.
- R8: After the pulse, channel i is released at the first edge that samples `cmdLo[i]` = 0. Each channel is released on its own. Until that edge, `gateLo[i]` stays 0 even while `cmdLo[i]` is 1.
- R9: A flag held high without a break produces one trip only. It must fall and requalify to trip again. A trip that qualifies during the release phase starts a new fault pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdLo | input | NUM_CH | Low-side gate commands, 1 = ON |
| ocFlag | input | 1 | Over-current comparator flag, 1 = above level |
| scFlag | input | 1 | Short-circuit comparator flag, 1 = above level |
| gateLo | output | NUM_CH | Gated low-side drives, 1 = ON |
| faultN | output | 1 | Fault indication, active low |

## Verification
`gateLo` depends combinationally on `cmdLo` and changes in the cycle the command changes. The trip takes effect at the edge that takes the qualifying sample. It is visible on `gateLo` and `faultN` in the cycle after that edge. A channel released at an edge that samples its command OFF follows its command from the next cycle. The bench drives inputs on the falling edge. For each cycle it pushes the outputs that a cycle model predicts for that cycle. The monitor compares them shortly after the same falling edge. Every check therefore sees exactly the registers updated by the preceding rising edge.

// File: rtl/lsTripPkg.sv
package lsTripPkg;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_FAULT   = 2'd1,
    ST_RECOVER = 2'd2
  } tripState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearTimer;
    logic runTimer;
    logic blockAll;
    logic allowRelease;
  } ctrlStrobe_t;

endpackage

// File: rtl/lsPulseFilter.sv
// Qualifies a flag: hit is high in the cycle whose sample completes
// QUAL_CYC consecutive high samples. The count saturates, so a flag
// held high gives a single hit until it falls.
module lsPulseFilter #(
  parameter int QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic flagIn,
  output logic hit
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic [CW-1:0] runCnt;

  assign hit = flagIn && (runCnt == CW'(QUAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!flagIn) begin
      runCnt <= '0;
    end else if (runCnt != CW'(QUAL_CYC)) begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lsTripDatapath.sv
module lsTripDatapath
  import lsTripPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SC_QUAL_CYC = 250,
  parameter int OC_QUAL_CYC = 1250,
  parameter int FAULT_CYC   = 225000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdLo,
  input  logic              ocFlag,
  input  logic              scFlag,
  input  ctrlStrobe_t       strobe,
  output logic              tripHit,
  output logic              timerDone,
  output logic              stillHeld,
  output logic [NUM_CH-1:0] gateLo
);
  localparam int TW = $clog2(FAULT_CYC + 1);

  logic              scHit;
  logic              ocHit;
  logic [TW-1:0]     faultTimer;
  logic [NUM_CH-1:0] blocked;

  lsPulseFilter #(.QUAL_CYC(SC_QUAL_CYC)) u_scFilter (
    .clk(clk), .rstN(rstN), .flagIn(scFlag), .hit(scHit)
  );

  lsPulseFilter #(.QUAL_CYC(OC_QUAL_CYC)) u_ocFilter (
    .clk(clk), .rstN(rstN), .flagIn(ocFlag), .hit(ocHit)
  );

  assign tripHit = scHit | ocHit;

  // fault duration timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultTimer <= '0;
    end else if (strobe.clearTimer) begin
      faultTimer <= '0;
    end else if (strobe.runTimer) begin
      faultTimer <= faultTimer + 1'b1;
    end
  end

  assign timerDone = (faultTimer == TW'(FAULT_CYC - 1));

  // per-channel block latch and gating
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blocked[ch] <= 1'b0;
      end else if (strobe.blockAll) begin
        blocked[ch] <= 1'b1;
      end else if (strobe.allowRelease && !cmdLo[ch]) begin
        blocked[ch] <= 1'b0;
      end
    end
    assign gateLo[ch] = cmdLo[ch] & ~blocked[ch];
  end

  // channels that remain blocked after this edge
  assign stillHeld = |(blocked & cmdLo);
endmodule

// File: rtl/lsTripControl.sv
module lsTripControl
  import lsTripPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tripHit,
  input  logic        timerDone,
  input  logic        stillHeld,
  output ctrlStrobe_t strobe,
  output logic        faultN
);
  tripState_e state;
  tripState_e stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_ARMED: begin
        if (tripHit) begin
          strobe.clearTimer = 1'b1;
          strobe.blockAll   = 1'b1;
          stateNext         = ST_FAULT;
        end
      end
      ST_FAULT: begin
        strobe.runTimer = 1'b1;
        if (timerDone) stateNext = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (tripHit) begin
          strobe.clearTimer = 1'b1;
          strobe.blockAll   = 1'b1;
          stateNext         = ST_FAULT;
        end else begin
          strobe.allowRelease = 1'b1;
          if (!stillHeld) stateNext = ST_ARMED;
        end
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  assign faultN = (state != ST_FAULT);
endmodule

// File: rtl/lsTripGuard.sv
module lsTripGuard
  import lsTripPkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int SC_QUAL_CYC = 250,
  parameter int OC_QUAL_CYC = 1250,
  parameter int FAULT_CYC   = 225000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdLo,
  input  logic              ocFlag,
  input  logic              scFlag,
  output logic [NUM_CH-1:0] gateLo,
  output logic              faultN
);
  ctrlStrobe_t strobe;
  logic        tripHit;
  logic        timerDone;
  logic        stillHeld;

  lsTripControl u_ctrl (
    .clk(clk), .rstN(rstN), .tripHit(tripHit), .timerDone(timerDone),
    .stillHeld(stillHeld), .strobe(strobe), .faultN(faultN)
  );

  lsTripDatapath #(
    .NUM_CH(NUM_CH), .SC_QUAL_CYC(SC_QUAL_CYC),
    .OC_QUAL_CYC(OC_QUAL_CYC), .FAULT_CYC(FAULT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmdLo(cmdLo), .ocFlag(ocFlag), .scFlag(scFlag),
    .strobe(strobe), .tripHit(tripHit), .timerDone(timerDone),
    .stillHeld(stillHeld), .gateLo(gateLo)
  );
endmodule

// File: rtl/lsTripGuardChk.sv
module lsTripGuardChk #(
  parameter int NUM_CH      = 3,
  parameter int SC_QUAL_CYC = 250,
  parameter int OC_QUAL_CYC = 1250,
  parameter int FAULT_CYC   = 225000
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cmdLo,
  input logic              ocFlag,
  input logic              scFlag,
  input logic [NUM_CH-1:0] gateLo,
  input logic              faultN
);
  localparam int SW = $clog2(SC_QUAL_CYC + 1);
  localparam int OW = $clog2(OC_QUAL_CYC + 1);
  localparam int LW = $clog2(FAULT_CYC + 2);

  logic [SW-1:0] scRun;
  logic [OW-1:0] ocRun;
  logic [LW-1:0] lowLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scRun  <= '0;
      ocRun  <= '0;
      lowLen <= '0;
    end else begin
      scRun  <= !scFlag ? '0 : (scRun == SW'(SC_QUAL_CYC) ? scRun : scRun + 1'b1);
      ocRun  <= !ocFlag ? '0 : (ocRun == OW'(OC_QUAL_CYC) ? ocRun : ocRun + 1'b1);
      lowLen <= faultN ? '0 : (lowLen == LW'(FAULT_CYC + 1) ? lowLen : lowLen + 1'b1);
    end
  end

  assert_sc_trip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (faultN && scFlag && scRun == SW'(SC_QUAL_CYC - 1)) |=> !faultN);

  assert_oc_trip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (faultN && ocFlag && ocRun == OW'(OC_QUAL_CYC - 1)) |=> !faultN);

  assert_trip_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> ($past(scFlag && scRun == SW'(SC_QUAL_CYC - 1)) ||
                       $past(ocFlag && ocRun == OW'(OC_QUAL_CYC - 1))));

  assert_gates_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |-> (gateLo == '0));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> (lowLen == LW'(FAULT_CYC)));

  assert_no_extend_R7: assert property (@(posedge clk) disable iff (!rstN)
    lowLen <= LW'(FAULT_CYC));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    assert_hold_until_off_R8: assert property (@(posedge clk) disable iff (!rstN)
      (cmdLo[ch] && $past(cmdLo[ch]) && !$past(gateLo[ch])) |-> !gateLo[ch]);
  end
endmodule

bind lsTripGuard lsTripGuardChk #(
  .NUM_CH(NUM_CH), .SC_QUAL_CYC(SC_QUAL_CYC),
  .OC_QUAL_CYC(OC_QUAL_CYC), .FAULT_CYC(FAULT_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdLo(cmdLo), .ocFlag(ocFlag), .scFlag(scFlag),
  .gateLo(gateLo), .faultN(faultN)
);

// File: tb/lsTripGuard_tb.sv
module lsTripGuard_tb;
  localparam int NCH = 3;
  localparam int SCQ = 4;
  localparam int OCQ = 10;
  localparam int FLT = 40;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] cmdLo = '0;
  logic           ocFlag = 1'b0;
  logic           scFlag = 1'b0;
  logic [NCH-1:0] gateLo;
  logic           faultN;

  always #4 clk = ~clk;  // 125 MHz

  lsTripGuard #(.NUM_CH(NCH), .SC_QUAL_CYC(SCQ), .OC_QUAL_CYC(OCQ), .FAULT_CYC(FLT)) u_dut (
    .clk(clk), .rstN(rstN), .cmdLo(cmdLo), .ocFlag(ocFlag), .scFlag(scFlag),
    .gateLo(gateLo), .faultN(faultN)
  );

  typedef struct {
    logic [NCH-1:0] gate;
    logic           fault;
    string          tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;

  // cycle model of the requirements
  int             mScRun = 0;
  int             mOcRun = 0;
  int             mLeft  = 0;
  bit             mFault = 0;
  bit             mRec   = 0;
  logic [NCH-1:0] mBlk   = '0;

  task automatic cyc(input logic [NCH-1:0] c, input logic oc, input logic sc, input string tag);
    expItem_t it;
    bit scHit;
    bit ocHit;
    @(negedge clk);
    cmdLo  = c;
    ocFlag = oc;
    scFlag = sc;
    it.gate  = c & ~mBlk;
    it.fault = !mFault;
    it.tag   = tag;
    expQ.push_back(it);
    scHit  = sc && (mScRun == SCQ - 1);
    ocHit  = oc && (mOcRun == OCQ - 1);
    mScRun = sc ? ((mScRun < SCQ) ? mScRun + 1 : SCQ) : 0;
    mOcRun = oc ? ((mOcRun < OCQ) ? mOcRun + 1 : OCQ) : 0;
    if (mFault) begin
      mLeft = mLeft - 1;
      if (mLeft == 0) begin
        mFault = 0;
        mRec   = 1;
      end
    end else if (scHit || ocHit) begin
      mFault = 1;
      mLeft  = FLT;
      mBlk   = '1;
      mRec   = 0;
    end else if (mRec) begin
      mBlk = mBlk & c;
      if (mBlk == '0) mRec = 0;
    end
  endtask

  task automatic run(input logic [NCH-1:0] c, input logic oc, input logic sc,
                     input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(c, oc, sc, tag);
  endtask

  // monitor: pops and compares away from the rising edge
  always @(negedge clk) begin
    expItem_t got;
    #2;
    while (expQ.size() > 0) begin
      got = expQ.pop_front();
      checks++;
      if (gateLo !== got.gate || faultN !== got.fault) begin
        fails++;
        $display("FAIL %s: gateLo=%b faultN=%b expected gateLo=%b faultN=%b",
                 got.tag, gateLo, faultN, got.gate, got.fault);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state, gates follow commands while in reset
    repeat (2) @(negedge clk);
    cmdLo = 3'b101;
    #2;
    checks++;
    if (faultN !== 1'b1 || gateLo !== 3'b101) begin
      fails++;
      $display("FAIL R1: gateLo=%b faultN=%b expected gateLo=101 faultN=1", gateLo, faultN);
    end
    @(negedge clk);
    rstN = 1'b1;
    run(3'b101, 0, 0, 2, "R1");
    run(3'b010, 0, 0, 2, "R1");
    run(3'b111, 0, 0, 2, "R1");

    // R2 boundary: one sample short of qualification
    run(3'b111, 0, 1, SCQ - 1, "R2");
    run(3'b111, 0, 0, 2, "R2");
    // R4: a single low sample restarts the count
    run(3'b111, 0, 1, SCQ - 1, "R4");
    cyc(3'b111, 0, 0, "R4");
    run(3'b111, 0, 1, SCQ - 1, "R4");
    cyc(3'b011, 0, 0, "R4");
    run(3'b110, 0, 0, 2, "R4");

    // R2/R5: qualified short-circuit trip with all channels commanded ON
    run(3'b111, 0, 1, SCQ, "R2");
    run(3'b111, 0, 0, 3, "R5");
    run(3'b101, 0, 0, 2, "R5");
    // R7: over-current qualifies during the pulse
    run(3'b111, 1, 0, OCQ + 2, "R7");
    // R6: pulse runs out with commands held ON
    run(3'b111, 0, 0, FLT, "R6");
    // R8: held ON channels stay blocked, then release one by one
    run(3'b111, 0, 0, 3, "R8");
    run(3'b110, 0, 0, 2, "R8");
    run(3'b111, 0, 0, 2, "R8");
    run(3'b011, 0, 0, 2, "R8");
    run(3'b111, 0, 0, 2, "R8");
    run(3'b001, 0, 0, 2, "R8");
    run(3'b111, 0, 0, 2, "R8");

    // R3: over-current boundary then trip
    run(3'b111, 1, 0, OCQ - 1, "R3");
    cyc(3'b111, 0, 0, "R3");
    run(3'b111, 1, 0, OCQ, "R3");
    // R9: flag held well past the pulse, no second trip
    run(3'b111, 1, 0, FLT + 12, "R9");
    run(3'b000, 1, 0, 2, "R9");
    run(3'b101, 1, 0, 3, "R9");
    // R9: falls and requalifies, trips again
    cyc(3'b111, 0, 0, "R9");
    run(3'b111, 1, 0, OCQ, "R9");
    run(3'b111, 0, 0, FLT + 2, "R6");
    // R9: trip during release phase starts a new pulse
    run(3'b110, 0, 1, SCQ, "R9");
    run(3'b110, 0, 0, FLT + 2, "R9");
    run(3'b000, 0, 0, 2, "R8");
    run(3'b011, 0, 0, 2, "R1");

    @(negedge clk);
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule